// File: doc/BRIEF.md
# Modulo-3 Running Sum Acceptor

This block recognises, one symbol per clock, whether the digits seen so far add up to a multiple of three. Each symbol is either a digit (0, 1 or 2) or an in-band clear symbol that empties the sum. The block never learns where a string ends. Its accept output therefore always reflects the whole string received so far.

The machine keeps only the residue of the sum modulo 3, so it needs three states. The state register, the next-state logic and the output logic are separate processes, and accept is a Moore output that depends on the state alone. The residue is also brought out so that it can be observed while debugging.

Top module: `mod3_acceptor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the residue becomes 0 and accept is high after that edge, whatever the symbol inputs are.
- R2: A valid digit d of 1 or 2, with the clear flag low, moves the residue from r to (r + d) mod 3 at the next rising edge.
- R3: A valid digit of 0, with the clear flag low, leaves the residue unchanged.
- R4: A valid symbol with the clear flag high sets the residue to 0 at the next edge, from any residue and with any digit value present.
- R5: While `sym_valid` is low, the residue and accept hold their values.
- R6: A valid digit value of 3, with the clear flag low, is illegal and leaves the residue unchanged.
- R7: Accept is high exactly when the residue is 0. It is valid in every cycle, including the cycle right after each symbol.
- R8: The residue output is the plain binary value 0, 1 or 2 and never shows 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A symbol is present in this cycle |
| sym_clear | input | 1 | The symbol is the clear symbol, which sets the sum to zero |
| sym_digit | input | 2 | Digit value 0, 1 or 2; the value 3 is illegal |
| accept | output | 1 | High when the running sum is a multiple of three |
| residue | output | 2 | Current running sum modulo 3 |

## Verification
There is one register between the inputs and both outputs. A symbol presented before a rising edge therefore shows up in `residue` and `accept` right after that edge, and the reset works the same way. The bench drives every symbol on a falling edge and removes it one nanosecond after the following rising edge. It then checks both outputs a nanosecond later, against a residue it keeps itself. Each check thus sees exactly one symbol's effect and never samples at an edge. For hold cases the bench leaves the inputs idle or illegal over an edge and then checks that nothing has moved.

// File: rtl/mod3_pkg.sv
// Package mod3_pkg
// Shared types and sizes for the modulo-3 acceptor.
// Assumes: residues are held in plain binary; code 3 is never legal.
package mod3_pkg;
    localparam int MODULUS = 3;
    localparam int RES_W   = $clog2(MODULUS);
    localparam int DIG_W   = 2;

    typedef enum logic [RES_W-1:0] {
        RES0    = 2'd0,
        RES1    = 2'd1,
        RES2    = 2'd2,
        RES_BAD = 2'd3
    } res_e;
endpackage

// File: rtl/mod3_next_state.sv
// Module mod3_next_state
// Combinational next-state logic of the residue machine.
// Assumes: the caller registers nxt on the clock; the illegal code
// RES_BAD returns to RES0; digit 3 and idle cycles hold the state.
module mod3_next_state
    import mod3_pkg::*;
(
    input  res_e             cur,
    input  logic             valid,
    input  logic             clear,
    input  logic [DIG_W-1:0] digit,
    output res_e             nxt
);
    // Residue after adding one.
    function automatic res_e add_one(input res_e r);
        case (r)
            RES0:    add_one = RES1;
            RES1:    add_one = RES2;
            RES2:    add_one = RES0;
            default: add_one = RES0;
        endcase
    endfunction

    // Residue after adding two.
    function automatic res_e add_two(input res_e r);
        case (r)
            RES0:    add_two = RES2;
            RES1:    add_two = RES0;
            RES2:    add_two = RES1;
            default: add_two = RES0;
        endcase
    endfunction

    // Pick the next residue from the current one and the symbol.
    always_comb begin
        nxt = cur;
        if (cur == RES_BAD) begin
            nxt = RES0;
        end else if (valid) begin
            if (clear) begin
                nxt = RES0;
            end else begin
                case (digit)
                    2'd0:    nxt = cur;
                    2'd1:    nxt = add_one(cur);
                    2'd2:    nxt = add_two(cur);
                    default: nxt = cur;
                endcase
            end
        end
    end
endmodule

// File: rtl/mod3_state_reg.sv
// Module mod3_state_reg
// Current-state register of the residue machine.
// Assumes: synchronous, active-low reset to RES0; the symbol inputs
// are passed in only for the assertions that guard this register.
module mod3_state_reg
    import mod3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             clear,
    input  logic [DIG_W-1:0] digit,
    input  res_e             nxt,
    output res_e             cur
);
    // Load the next residue every clock; reset wins.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= RES0;
        else        cur <= nxt;
    end

    // R1: reset lands in residue 0.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> cur == RES0);

    // R4: clear symbol forces residue 0.
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && clear) |=> cur == RES0);

    // R5: no symbol, no move.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cur));

    // R6: illegal digit 3 holds.
    a_r6_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear && digit == 2'd3) |=> $stable(cur));

    // R2: a legal digit adds modulo 3.
    a_r2_add_mod3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear && digit != 2'd3) |=>
        ({1'b0, cur} == ({1'b0, $past(cur)} + {1'b0, $past(digit)}) % 3'd3));
endmodule

// File: rtl/mod3_output.sv
// Module mod3_output
// Moore output logic: accept and debug residue from the state only.
// Assumes: state comes straight from the state register.
module mod3_output
    import mod3_pkg::*;
(
    input  res_e             cur,
    output logic             accept,
    output logic [RES_W-1:0] residue
);
    // Decode accept from the state; unknown codes do not accept.
    always_comb begin
        case (cur)
            RES0:    accept = 1'b1;
            RES1:    accept = 1'b0;
            RES2:    accept = 1'b0;
            default: accept = 1'b0;
        endcase
    end

    // Expose the residue code for debug.
    always_comb begin
        residue = cur;
    end
endmodule

// File: rtl/mod3_acceptor.sv
// Module mod3_acceptor
// Top level: accepts when the running digit sum is divisible by 3.
// Assumes: one symbol per clock when sym_valid is high; synchronous
// active-low reset; outputs are registered-state Moore outputs.
module mod3_acceptor
    import mod3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             sym_clear,
    input  logic [DIG_W-1:0] sym_digit,
    output logic             accept,
    output logic [RES_W-1:0] residue
);
    res_e cur_st;
    res_e nxt_st;

    mod3_next_state u_next (
        .cur   (cur_st),
        .valid (sym_valid),
        .clear (sym_clear),
        .digit (sym_digit),
        .nxt   (nxt_st)
    );

    mod3_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (sym_valid),
        .clear (sym_clear),
        .digit (sym_digit),
        .nxt   (nxt_st),
        .cur   (cur_st)
    );

    mod3_output u_out (
        .cur     (cur_st),
        .accept  (accept),
        .residue (residue)
    );

    // R8: the debug residue never shows the unused code.
    a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        residue != 2'd3);

    // R7: accept changes only when a symbol or reset was present.
    a_r7_accept_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(accept));
endmodule

// File: tb/tb_mod3_acceptor.sv
`timescale 1ns/1ps
module tb_mod3_acceptor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic       sym_clear = 1'b0;
    logic [1:0] sym_digit = 2'd0;
    logic       accept;
    logic [1:0] residue;

    int n_chk = 0;
    int n_bad = 0;
    int exp_res = 0;

    always #2.5 clk = ~clk;

    mod3_acceptor dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .sym_clear(sym_clear), .sym_digit(sym_digit),
        .accept(accept), .residue(residue)
    );

    // Compare both outputs with the bench model.
    task automatic check(input string req);
        n_chk++;
        if (residue !== 2'(exp_res) || accept !== (exp_res == 0)) begin
            n_bad++;
            $display("FAIL %s: residue=%0d accept=%0b expected residue=%0d accept=%0b",
                     req, residue, accept, exp_res, exp_res == 0);
        end
        if (residue === 2'd3) begin
            n_bad++;
            $display("FAIL R8: residue=3 expected 0..2");
        end
    endtask

    // Present one symbol for one edge, update model, check after edge.
    task automatic apply(input logic v, input logic c, input logic [1:0] d,
                         input string req);
        @(negedge clk);
        sym_valid = v; sym_clear = c; sym_digit = d;
        if (v) begin
            if (c) exp_res = 0;
            else if (d != 2'd3) exp_res = (exp_res + int'(d)) % 3;
        end
        @(posedge clk);
        #1;
        sym_valid = 1'b0; sym_clear = 1'b0; sym_digit = 2'd0;
        #1;
        check(req);
    endtask

    // R1: reset with noisy symbol inputs.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; sym_valid = 1'b1; sym_digit = 2'd1;
        exp_res = 0;
        @(posedge clk);
        #1;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1; sym_valid = 1'b0; sym_digit = 2'd0;
    endtask

    // R2/R7: walk the residue through every value with 1s and 2s.
    task automatic t_digits();
        apply(1, 0, 2'd1, "R2");
        apply(1, 0, 2'd1, "R2");
        apply(1, 0, 2'd1, "R7");
        apply(1, 0, 2'd2, "R2");
        apply(1, 0, 2'd2, "R2");
        apply(1, 0, 2'd2, "R7");
        apply(1, 0, 2'd2, "R2");
        apply(1, 0, 2'd1, "R7");
    endtask

    // R3: digit 0 from each residue.
    task automatic t_zero();
        for (int k = 0; k < 3; k++) begin
            apply(1, 0, 2'd0, "R3");
            apply(1, 0, 2'd1, "R2");
        end
    endtask

    // R4: clear from each residue with each digit value.
    task automatic t_clear();
        for (int r = 1; r < 3; r++) begin
            for (int d = 0; d < 4; d++) begin
                apply(1, 0, 2'(r), "R2");
                apply(1, 1, 2'(d), "R4");
            end
        end
        apply(1, 1, 2'd2, "R4");
    endtask

    // R5: idle cycles with active digit and clear lines.
    task automatic t_idle();
        apply(1, 0, 2'd2, "R2");
        apply(0, 0, 2'd1, "R5");
        apply(0, 1, 2'd2, "R5");
        apply(0, 0, 2'd2, "R5");
    endtask

    // R6: illegal digit from two residues.
    task automatic t_illegal();
        apply(1, 0, 2'd3, "R6");
        apply(1, 0, 2'd1, "R2");
        apply(1, 0, 2'd3, "R6");
        apply(1, 0, 2'd3, "R6");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        exp_res = 0;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        t_digits();
        t_zero();
        t_clear();
        t_idle();
        t_illegal();
        apply(1, 0, 2'd1, "R2");
        t_reset();
        t_digits();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule